// File: doc/BRIEF.md
# Barrel Shifter with Carry-Out

This block shifts or rotates a 32-bit operand by a variable count and returns both the shifted word and a carry-out bit. It supports four kinds of shift: logical left, logical right, arithmetic right and rotate right. The count comes from one of two sources, selected by a flag. It is either a short field taken from the instruction word or the low byte of a general register. The block is meant to sit in front of an integer ALU, and it supplies the second operand and the shifter carry.

The two count sources treat zero in different ways. A register count of zero leaves both the word and the carry alone, for every kind. An immediate count of zero has a special meaning for three of the four kinds: a right shift by the full width, or a one-place rotate through the carry. Counts equal to the word width and counts above it follow fixed result and carry rules. The datapath is combinational. One output register stage holds the result, and a valid bit travels alongside it.

Top module: `bshift_unit`

## Requirements
- R1: While rst_ni is low, valid_o, result_o and carry_o are all zero.
- R2: A request presented with valid_i high at a rising edge shows up on result_o and carry_o, with valid_o high, after that edge. Edges with valid_i low leave result_o and carry_o unchanged and drive valid_o low.
- R3: kind_i encodes 2'b00 logical left, 2'b01 logical right, 2'b10 arithmetic right, 2'b11 rotate right. For counts 1 to 31, carry_o is the last bit moved out of the word.
- R4: When amt_from_reg_i is 0, only amount_i[4:0] forms the count, and amount_i[7:5] has no effect.
- R5: An immediate logical left by 0 returns value_i unchanged, and carry_o equals carry_i.
- R6: An immediate logical right by 0 acts as logical right by 32. An immediate arithmetic right by 0 acts as arithmetic right by 32.
- R7: An immediate rotate right by 0 rotates one place through the carry. carry_i enters bit 31, and bit 0 of value_i becomes carry_o.
- R8: When amt_from_reg_i is 1, all 8 bits of amount_i form the count. A count of 0 returns value_i and carry_i unchanged for every kind.
- R9: Logical left by 32 gives zero with carry_o equal to bit 0. Logical left by more than 32 gives zero with carry_o equal to 0.
- R10: Logical right by 32 gives zero with carry_o equal to bit 31. Logical right by more than 32 gives zero with carry_o equal to 0.
- R11: Arithmetic right by 32 or more copies bit 31 into every result bit and into carry_o.
- R12: Rotate right by 32 returns value_i with carry_o equal to bit 31. Rotate right by a larger count behaves like rotate right by the count minus a multiple of 32 (a multiple of 32 behaves like 32).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| value_i | input | 32 | Operand to shift |
| kind_i | input | 2 | Shift kind (R3 encoding) |
| amount_i | input | 8 | Shift count |
| amt_from_reg_i | input | 1 | 1: count is a register byte; 0: count is an immediate field |
| carry_i | input | 1 | Incoming carry |
| valid_o | output | 1 | Result strobe |
| result_o | output | 32 | Shifted word |
| carry_o | output | 1 | Shifter carry-out |

## Verification
Each result is due exactly one rising edge after its request is taken. The driver applies every request on a falling edge and pushes the model's expected word and carry into a queue at the same moment. The monitor pops one entry on each falling edge at which valid_o is high, so it compares half a cycle after the register has settled. Idle edges are checked separately: the bench changes the inputs with valid_i low and confirms that the registered outputs keep their last value.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_ROR = 2'b11
  } shift_kind_e;

  typedef enum logic [1:0] {
    MODE_PASS  = 2'b00,
    MODE_RRX   = 2'b01,
    MODE_SHIFT = 2'b10
  } shift_mode_e;

endpackage

// File: rtl/bshift_amount_norm.sv
module bshift_amount_norm
  import bshift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8,
  parameter int CNT_W  = 8
) (
  input  shift_kind_e       kind_i,
  input  logic [AMT_W-1:0]  amount_i,
  input  logic              from_reg_i,
  output shift_mode_e       mode_o,
  output logic [CNT_W-1:0]  count_o
);
  localparam int LOG_W = $clog2(DATA_W);

  logic [LOG_W-1:0] imm_amt;
  assign imm_amt = amount_i[LOG_W-1:0];

  always_comb begin
    mode_o  = MODE_SHIFT;
    count_o = from_reg_i ? CNT_W'(amount_i) : CNT_W'(imm_amt);
    if (from_reg_i) begin
      if (amount_i == '0) mode_o = MODE_PASS;
    end else if (imm_amt == '0) begin
      // immediate zero is re-read per kind
      unique case (kind_i)
        SK_LSL:  mode_o = MODE_PASS;
        SK_ROR:  mode_o = MODE_RRX;
        default: count_o = CNT_W'(DATA_W);
      endcase
    end
  end

endmodule

// File: rtl/bshift_rotator.sv
module bshift_rotator #(
  parameter int DATA_W = 32,
  localparam int LOG_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [LOG_W-1:0]  rot_i,
  output logic [DATA_W-1:0] data_o
);
  // log-depth rotate right, one stage per count bit
  always_comb begin
    logic [DATA_W-1:0] cur;
    cur = data_i;
    for (int i = 0; i < LOG_W; i++) begin
      if (rot_i[i]) cur = (cur >> (1 << i)) | (cur << (DATA_W - (1 << i)));
    end
    data_o = cur;
  end

endmodule

// File: rtl/bshift_core.sv
module bshift_core
  import bshift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic [DATA_W-1:0] value_i,
  input  shift_kind_e       kind_i,
  input  shift_mode_e       mode_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o
);
  localparam int LOG_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DATA_W);

  logic [DATA_W-1:0] value_rev, rot_src, rot_out, low_mask, masked, masked_rev;
  logic [LOG_W-1:0]  rot_amt;
  logic              cnt_lt, cnt_eq, sign_b;

  // left shift reuses the right rotator on a bit-reversed word
  for (genvar g = 0; g < DATA_W; g++) begin : g_rev
    assign value_rev[g]  = value_i[DATA_W-1-g];
    assign masked_rev[g] = masked[DATA_W-1-g];
  end

  assign rot_amt  = count_i[LOG_W-1:0];
  assign rot_src  = (kind_i == SK_LSL) ? value_rev : value_i;
  assign low_mask = {DATA_W{1'b1}} >> rot_amt;
  assign masked   = rot_out & low_mask;
  assign cnt_lt   = count_i < FULL_CNT;
  assign cnt_eq   = count_i == FULL_CNT;
  assign sign_b   = value_i[DATA_W-1];

  bshift_rotator #(.DATA_W(DATA_W)) u_rot (
    .data_i (rot_src),
    .rot_i  (rot_amt),
    .data_o (rot_out)
  );

  always_comb begin
    result_o = value_i;
    carry_o  = carry_i;
    unique case (mode_i)
      MODE_PASS: ;
      MODE_RRX: begin
        result_o = {carry_i, value_i[DATA_W-1:1]};
        carry_o  = value_i[0];
      end
      default: begin
        unique case (kind_i)
          SK_LSL: begin
            if (cnt_lt) begin
              result_o = masked_rev;
              carry_o  = rot_out[DATA_W-1];
            end else begin
              result_o = '0;
              carry_o  = cnt_eq & value_i[0];
            end
          end
          SK_LSR: begin
            if (cnt_lt) begin
              result_o = masked;
              carry_o  = rot_out[DATA_W-1];
            end else begin
              result_o = '0;
              carry_o  = cnt_eq & sign_b;
            end
          end
          SK_ASR: begin
            if (cnt_lt) begin
              result_o = masked | ({DATA_W{sign_b}} & ~low_mask);
              carry_o  = rot_out[DATA_W-1];
            end else begin
              result_o = {DATA_W{sign_b}};
              carry_o  = sign_b;
            end
          end
          default: begin
            // counts that are a multiple of the width act as a full turn
            result_o = rot_out;
            carry_o  = rot_out[DATA_W-1];
          end
        endcase
      end
    endcase
  end

endmodule

// File: rtl/bshift_unit.sv
module bshift_unit
  import bshift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] value_i,
  input  logic [1:0]        kind_i,
  input  logic [AMT_W-1:0]  amount_i,
  input  logic              amt_from_reg_i,
  input  logic              carry_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o
);
  localparam int LOG_W = $clog2(DATA_W);
  localparam int CNT_W = (AMT_W > LOG_W) ? AMT_W : LOG_W + 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DATA_W);

  shift_kind_e       kind;
  shift_mode_e       mode;
  logic [CNT_W-1:0]  count;
  logic [DATA_W-1:0] res_d;
  logic              carry_d;

  assign kind = shift_kind_e'(kind_i);

  bshift_amount_norm #(.DATA_W(DATA_W), .AMT_W(AMT_W), .CNT_W(CNT_W)) u_norm (
    .kind_i     (kind),
    .amount_i   (amount_i),
    .from_reg_i (amt_from_reg_i),
    .mode_o     (mode),
    .count_o    (count)
  );

  bshift_core #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_core (
    .value_i  (value_i),
    .kind_i   (kind),
    .mode_i   (mode),
    .count_i  (count),
    .carry_i  (carry_i),
    .result_o (res_d),
    .carry_o  (carry_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      carry_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= res_d;
        carry_o  <= carry_d;
      end
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && $stable(result_o) && $stable(carry_o));

  a_r8_reg_zero_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && amt_from_reg_i && amount_i == '0
    |=> result_o == $past(value_i) && carry_o == $past(carry_i));

  a_r9_lsl_beyond: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && amt_from_reg_i && kind_i == 2'b00 && CNT_W'(amount_i) > FULL_CNT
    |=> result_o == '0 && !carry_o);

  a_r11_asr_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && amt_from_reg_i && kind_i == 2'b10 && CNT_W'(amount_i) >= FULL_CNT
    |=> result_o == {DATA_W{$past(value_i[DATA_W-1])}}
        && carry_o == $past(value_i[DATA_W-1]));

  a_r7_rrx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !amt_from_reg_i && kind_i == 2'b11 && amount_i[LOG_W-1:0] == '0
    |=> result_o[DATA_W-1] == $past(carry_i) && carry_o == $past(value_i[0]));

endmodule

// File: tb/bshift_unit_tb.sv
`timescale 1ns/1ps
module bshift_unit_tb;
  localparam int DW = 32;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [DW-1:0] value_i = '0;
  logic [1:0]    kind_i = '0;
  logic [AW-1:0] amount_i = '0;
  logic          amt_from_reg_i = 1'b0;
  logic          carry_i = 1'b0;
  logic          valid_o;
  logic [DW-1:0] result_o;
  logic          carry_o;

  always #10 clk = ~clk;

  bshift_unit #(.DATA_W(DW), .AMT_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .value_i(value_i),
    .kind_i(kind_i), .amount_i(amount_i), .amt_from_reg_i(amt_from_reg_i),
    .carry_i(carry_i), .valid_o(valid_o), .result_o(result_o), .carry_o(carry_o)
  );

  typedef struct {
    logic [DW-1:0] res;
    logic          c;
    string         req;
  } exp_t;

  exp_t sb[$];
  int   total = 0;
  int   bad   = 0;
  bit   done  = 1'b0;

  // bit-at-a-time reference
  function automatic logic [DW:0] model(logic [DW-1:0] v, logic [1:0] k,
                                        logic [AW-1:0] a, logic fr, logic cin);
    int n;
    logic [DW-1:0] r = v;
    logic c = cin;
    if (!fr) begin
      n = int'(a[4:0]);
      if (n == 0) begin
        if (k == 2'b00) return {cin, v};
        if (k == 2'b11) return {v[0], cin, v[DW-1:1]};
        n = DW;
      end
    end else begin
      n = int'(a);
      if (n == 0) return {cin, v};
    end
    for (int i = 0; i < n; i++) begin
      case (k)
        2'b00: begin c = r[DW-1]; r = {r[DW-2:0], 1'b0}; end
        2'b01: begin c = r[0]; r = {1'b0, r[DW-1:1]}; end
        2'b10: begin c = r[0]; r = {r[DW-1], r[DW-1:1]}; end
        default: begin c = r[0]; r = {r[0], r[DW-1:1]}; end
      endcase
    end
    return {c, r};
  endfunction

  task automatic check(bit ok, string req, logic [DW:0] got, logic [DW:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got c=%0b r=%h expected c=%0b r=%h",
               req, got[DW], got[DW-1:0], exp[DW], exp[DW-1:0]);
    end
  endtask

  task automatic drive(logic [DW-1:0] v, logic [1:0] k, logic [AW-1:0] a,
                       logic fr, logic cin, string req);
    exp_t e;
    logic [DW:0] m;
    @(negedge clk);
    valid_i = 1'b1; value_i = v; kind_i = k; amount_i = a;
    amt_from_reg_i = fr; carry_i = cin;
    m = model(v, k, a, fr, cin);
    e.res = m[DW-1:0]; e.c = m[DW]; e.req = req;
    sb.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0;
    end
  endtask

  // monitor: one entry per valid result
  always @(negedge clk) begin
    if (rst_ni && valid_o) begin
      if (sb.size() == 0) begin
        check(1'b0, "R2", {carry_o, result_o}, '0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(result_o === e.res && carry_o === e.c, e.req,
              {carry_o, result_o}, {e.c, e.res});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  localparam logic [DW-1:0] A = 32'h8000_0001;
  localparam logic [DW-1:0] B = 32'h7FFF_FFFE;
  localparam logic [DW-1:0] P = 32'hC3A5_5A3C;

  initial begin
    logic [DW:0] held;
    repeat (2) @(negedge clk);
    // R1 reset values
    check(valid_o == 1'b0, "R1", {1'b0, 31'b0, valid_o}, '0);
    check(result_o == '0, "R1", {carry_o, result_o}, '0);
    check(carry_o == 1'b0, "R1", {carry_o, result_o}, '0);
    @(negedge clk); rst_ni = 1'b1;

    // R3 counts 1..31 for each kind
    drive(P, 2'b00, 8'd1, 1'b1, 1'b0, "R3");
    drive(P, 2'b00, 8'd31, 1'b1, 1'b0, "R3");
    drive(P, 2'b01, 8'd4, 1'b0, 1'b0, "R3");
    drive(A, 2'b10, 8'd7, 1'b1, 1'b0, "R3");
    drive(B, 2'b10, 8'd3, 1'b0, 1'b1, "R3");
    drive(P, 2'b11, 8'd13, 1'b1, 1'b0, "R3");
    drive(A, 2'b11, 8'd1, 1'b0, 1'b0, "R3");
    // R4 upper immediate bits ignored
    drive(P, 2'b00, 8'hE3, 1'b0, 1'b0, "R4");
    drive(P, 2'b01, 8'hA0, 1'b0, 1'b0, "R4");
    // R5 immediate left by zero
    drive(P, 2'b00, 8'd0, 1'b0, 1'b1, "R5");
    drive(P, 2'b00, 8'd0, 1'b0, 1'b0, "R5");
    // R6 immediate right by zero
    drive(A, 2'b01, 8'd0, 1'b0, 1'b0, "R6");
    drive(A, 2'b10, 8'd0, 1'b0, 1'b0, "R6");
    drive(B, 2'b10, 8'd0, 1'b0, 1'b1, "R6");
    // R7 rotate through carry
    drive(A, 2'b11, 8'd0, 1'b0, 1'b0, "R7");
    drive(B, 2'b11, 8'd0, 1'b0, 1'b1, "R7");
    // R8 register count zero, every kind
    for (int k = 0; k < 4; k++) drive(P, 2'(k), 8'd0, 1'b1, 1'b1, "R8");
    drive(P, 2'b01, 8'd200, 1'b1, 1'b0, "R8");
    // R9 left at and beyond width
    drive(A, 2'b00, 8'd32, 1'b1, 1'b0, "R9");
    drive(B, 2'b00, 8'd32, 1'b1, 1'b1, "R9");
    drive(A, 2'b00, 8'd33, 1'b1, 1'b1, "R9");
    // R10 logical right at and beyond width
    drive(A, 2'b01, 8'd32, 1'b1, 1'b0, "R10");
    drive(A, 2'b01, 8'd40, 1'b1, 1'b1, "R10");
    // R11 arithmetic right at and beyond width
    drive(A, 2'b10, 8'd32, 1'b1, 1'b0, "R11");
    drive(B, 2'b10, 8'd255, 1'b1, 1'b1, "R11");
    // R12 rotate at and beyond width
    drive(P, 2'b11, 8'd32, 1'b1, 1'b0, "R12");
    drive(P, 2'b11, 8'd64, 1'b1, 1'b0, "R12");
    drive(P, 2'b11, 8'd45, 1'b1, 1'b0, "R12");
    drive(A, 2'b11, 8'd255, 1'b1, 1'b0, "R12");

    // R2 idle edges hold outputs
    drive(P, 2'b01, 8'd5, 1'b1, 1'b0, "R2");
    held = model(P, 2'b01, 8'd5, 1'b1, 1'b0);
    @(negedge clk);
    valid_i = 1'b0; value_i = ~P; kind_i = 2'b00; amount_i = 8'd1; carry_i = 1'b1;
    @(negedge clk);
    check(valid_o == 1'b0, "R2", {1'b0, 31'b0, valid_o}, '0);
    check({carry_o, result_o} == held, "R2", {carry_o, result_o}, held);
    @(negedge clk);
    check({carry_o, result_o} == held, "R2", {carry_o, result_o}, held);

    // mixed patterns
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a;
      int sel;
      sel = int'($urandom_range(0, 9));
      case (sel)
        0: a = 8'd0;
        1: a = 8'd31;
        2: a = 8'd32;
        3: a = 8'd33;
        4: a = 8'd96;
        default: a = AW'($urandom);
      endcase
      drive(DW'($urandom), 2'($urandom), a, 1'($urandom), 1'($urandom), "R3");
      if (sel == 9) idle(1);
    end
    idle(3);
    check(sb.size() == 0, "R2", DW'(sb.size()), '0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule